// File: doc/BRIEF.md
# SCSI Initiator Selection Sequencer

This block carries a simple SCSI host adapter through selection and the command phase. Command bytes are first gathered in a 32-byte command buffer, loaded either by FIFO writes or by a DMA read port. The host then issues a select command. The block works out the target from the destination ID register and a bitmap of the targets that are present. It splits the buffer into an identify byte and the command proper, and hands the command to a downstream target model through a one-cycle strobe. The target model answers with a signed expected data length. From that length the block loads its status, interrupt-reason and sequence-step registers and raises the interrupt line.

There is no bus-level handshaking. The block moves straight to the register values the host would see once selection has finished. A select-and-stop variant halts after the identify byte and keeps the command open. Later buffer writes extend it, and a transfer command finally sends it.

Host command codes on `cmd_code` are: 0 no-op, 1 select with attention, 2 select with attention and stop, 3 transfer.

Top module: `scsi_sel_seq`

## Requirements
- R1: After reset, the following are all zero: `stat_reg`, `intr_reg`, `seq_step`, `irq`, `cmd_issue`, `cmd_cancel`, `cmd_len`, `cmd_lun` and `cmd_tgt`.
- R2: The target ID is `dest_id[2:0]`; the upper bits are ignored. A select (code 1 or 2) to ID 7, or to an ID whose `tgt_present` bit is 0, has these effects on the next cycle:
  - `stat_reg` = 0x80, `intr_reg` = 0x20 and `seq_step` = 0.
  - `irq` = 1.
  - No strobe is issued.
  - The buffer count is cleared.
- R3: A select with code 1 to a present target pulses `cmd_issue` for exactly one cycle, starting on the cycle after the command. While the strobe is high:
  - `cmd_tgt` holds the target ID.
  - `cmd_lun` holds identify[2:0].
  - `cmd_len` holds the number of command bytes.
  - `cmd_rdata` returns command byte `cmd_raddr`, counted from 0. The identify byte is excluded.
- R4: Where the identify byte comes from depends on `cmd_dma`:
  - `cmd_dma` = 0: a zero identify byte is placed in front, and every buffered byte is a command byte.
  - `cmd_dma` = 1: the first buffered byte is the identify byte, and the bytes after it are the command.
- R5: On the cycle after the strobe, the block samples `exp_len`. The status register is set as follows:
  - `exp_len` > 0: `stat_reg` = 0x91.
  - `exp_len` < 0: `stat_reg` = 0x90.
  - `exp_len` = 0: `stat_reg` is left unchanged.

  In every case `intr_reg` = 0x18, `seq_step` = 4 and `irq` = 1.
- R6: A select with code 2 to a present target has these effects on the next cycle:
  - `stat_reg` = 0x92, `intr_reg` = 0x18, `seq_step` = 4 and `irq` = 1.
  - No strobe is issued.
  - The command is marked pending, and the buffered bytes are kept.
- R7: While a command is pending:
  - Buffer writes append to it.
  - A transfer (code 3) issues the whole collected command as in R3, clears the buffer count and clears the pending mark.

  A transfer with nothing pending has no effect. Any select clears an earlier pending mark.
- R8: A select arriving while an issued command has not yet seen `tgt_done` pulses `cmd_cancel` for one cycle, on the next cycle.
- R9: `irq` stays high until `intr_rd`. `intr_rd` clears `irq` and `stat_reg[7]` on the next cycle, unless a new event lands on that same edge. A new event overwrites `intr_reg` whether or not `irq` is still high.
- R10: While `bus_rst` is high, selects are ignored. No register changes and no interrupt is raised.
- R11: Buffer capacity is 32 bytes:
  - Writes beyond 32 bytes are dropped.
  - When `dma_wr` and `fifo_wr` are high in the same cycle, the `dma_data` byte is stored.
  - A write on the same edge as a buffer clear is dropped.
- R12: Commands presented in the cycle in which `cmd_issue` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset in progress; blocks selects |
| cmd_valid | input | 1 | Host command strobe |
| cmd_code | input | 2 | Command code (0 no-op, 1 select, 2 select-stop, 3 transfer) |
| cmd_dma | input | 1 | DMA mode for this select |
| dest_id | input | 8 | Destination ID register |
| tgt_present | input | 7 | One bit per target that exists |
| fifo_wr | input | 1 | FIFO byte write |
| fifo_data | input | 8 | FIFO byte |
| dma_wr | input | 1 | DMA read-port byte valid |
| dma_data | input | 8 | DMA byte |
| exp_len | input | 17 | Signed expected data length from the target model |
| tgt_done | input | 1 | Target model finished the active command |
| intr_rd | input | 1 | Host reads the interrupt register |
| cmd_raddr | input | 5 | Command byte index for the target model |
| cmd_issue | output | 1 | Command-ready strobe |
| cmd_tgt | output | 3 | Selected target |
| cmd_lun | output | 3 | LUN from the identify byte |
| cmd_len | output | 6 | Command byte count |
| cmd_rdata | output | 8 | Command byte at `cmd_raddr` |
| cmd_cancel | output | 1 | Old command cancelled |
| stat_reg | output | 8 | Status register |
| intr_reg | output | 8 | Interrupt reason register |
| seq_step | output | 3 | Sequence step |
| irq | output | 1 | Interrupt line |

## Verification
Selects are tried with the following target IDs, and each one tells apart a different fault:
- Absent, present, ID 7, and an ID whose upper bits are set. These separate the presence lookup from the masking of the ID field.
- Positive, negative and zero expected lengths. These separate the three status outcomes.
- The same byte pattern loaded through FIFO and through DMA mode. This separates the inserted zero identify byte from an identify byte taken out of the buffer.

Sequences then exercise the ordering rules: select-and-stop followed by appended bytes and a transfer, back-to-back selects with and without `tgt_done`, a command in the strobe cycle, a select under bus reset, and a buffer overrun.

// File: rtl/scsi_sel_pkg.sv
package scsi_sel_pkg;

  typedef enum logic [1:0] {
    OP_NOP      = 2'd0,
    OP_SEL      = 2'd1,
    OP_SEL_STOP = 2'd2,
    OP_XFER     = 2'd3
  } sel_op_e;

  localparam logic [7:0] ST_INT      = 8'h80;
  localparam logic [7:0] ST_TC       = 8'h10;
  localparam logic [7:0] PH_DATA_IN  = 8'h01;
  localparam logic [7:0] PH_DATA_OUT = 8'h00;
  localparam logic [7:0] PH_CMD      = 8'h02;
  localparam logic [7:0] IR_DISC     = 8'h20;
  localparam logic [7:0] IR_SVC_DONE = 8'h18;
  localparam logic [2:0] SEQ_IDLE    = 3'd0;
  localparam logic [2:0] SEQ_CMD     = 3'd4;

  // Status after the target reports its expected length.
  function automatic logic [7:0] data_status(input logic len_neg, input logic len_zero,
                                             input logic [7:0] old_stat);
    if (len_zero)     return old_stat;
    else if (len_neg) return ST_INT | ST_TC | PH_DATA_OUT;
    else              return ST_INT | ST_TC | PH_DATA_IN;
  endfunction

  // Command byte count once the identify byte is removed.
  function automatic logic [5:0] body_len(input logic [5:0] cnt, input logic id_in_buf);
    return cnt - {5'd0, id_in_buf};
  endfunction

endpackage

// File: rtl/scsi_cmd_buf.sv
module scsi_cmd_buf #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [7:0]    wdata,
  input  logic          clr,
  input  logic [CW-1:0] rd_idx,
  output logic [7:0]    rdata,
  output logic [7:0]    byte0,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q;
  logic          full;
  logic          wr_en;
  logic [7:0]    ent [DEPTH];

  assign full  = (cnt_q == CW'(DEPTH));
  assign wr_en = wr && !clr && !full;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [7:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ent_q <= '0;
      else if (wr_en && cnt_q == CW'(i))     ent_q <= wdata;
    end
    assign ent[i] = ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (wr_en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt   = cnt_q;
  assign byte0 = ent[0];
  assign rdata = (rd_idx < CW'(DEPTH)) ? ent[rd_idx[AW-1:0]] : 8'h00;
endmodule

// File: rtl/scsi_sel_ctrl.sv
module scsi_sel_ctrl
  import scsi_sel_pkg::*;
#(
  parameter int NTGT = 7,
  parameter int CW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_code,
  input  logic            cmd_dma,
  input  logic [2:0]      tgt_id,
  input  logic [NTGT-1:0] tgt_present,
  input  logic            tgt_done,
  input  logic [CW-1:0]   buf_cnt,
  input  logic [7:0]      buf_byte0,
  output logic            ev_sel,
  output logic            ev_fail,
  output logic            ev_stop,
  output logic            ev_go,
  output logic            buf_clr,
  output logic            pend,
  output logic            active,
  output logic            id_off,
  output logic            cmd_issue,
  output logic            cmd_cancel,
  output logic [2:0]      cmd_tgt,
  output logic [2:0]      cmd_lun,
  output logic [CW-1:0]   cmd_len
);
  sel_op_e    op;
  logic [7:0] pres_ext;
  logic       tgt_ok, ev_sel_go, ev_xfer, off_next;
  logic       issue_q, cancel_q, pend_q, active_q, off_q;
  logic [2:0] tgt_q, lun_q;
  logic [CW-1:0] len_q;

  assign op       = sel_op_e'(cmd_code);
  assign pres_ext = 8'(tgt_present);
  assign tgt_ok   = (32'(tgt_id) < NTGT) && pres_ext[tgt_id];

  assign ev_sel    = cmd_valid && (op == OP_SEL || op == OP_SEL_STOP) && !bus_rst && !issue_q;
  assign ev_fail   = ev_sel && !tgt_ok;
  assign ev_stop   = ev_sel && tgt_ok && (op == OP_SEL_STOP);
  assign ev_sel_go = ev_sel && tgt_ok && (op == OP_SEL);
  assign ev_xfer   = cmd_valid && (op == OP_XFER) && pend_q && !issue_q;
  assign ev_go     = ev_sel_go || ev_xfer;
  assign buf_clr   = ev_fail || ev_go;
  assign off_next  = cmd_dma && (buf_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_q  <= 1'b0;
      cancel_q <= 1'b0;
      pend_q   <= 1'b0;
      active_q <= 1'b0;
      off_q    <= 1'b0;
      tgt_q    <= '0;
      lun_q    <= '0;
      len_q    <= '0;
    end else begin
      issue_q  <= ev_go;
      cancel_q <= ev_sel && active_q;
      if (ev_go)                   active_q <= 1'b1;
      else if (ev_sel || tgt_done) active_q <= 1'b0;
      if (ev_sel)       pend_q <= ev_stop;
      else if (ev_xfer) pend_q <= 1'b0;
      if (ev_sel && tgt_ok) begin
        off_q <= off_next;
        tgt_q <= tgt_id;
        lun_q <= off_next ? buf_byte0[2:0] : 3'd0;
      end
      if (ev_sel_go)    len_q <= body_len(buf_cnt, off_next);
      else if (ev_xfer) len_q <= body_len(buf_cnt, off_q);
    end
  end

  assign pend       = pend_q;
  assign active     = active_q;
  assign id_off     = off_q;
  assign cmd_issue  = issue_q;
  assign cmd_cancel = cancel_q;
  assign cmd_tgt    = tgt_q;
  assign cmd_lun    = lun_q;
  assign cmd_len    = len_q;
endmodule

// File: rtl/scsi_sel_seq.sv
module scsi_sel_seq
  import scsi_sel_pkg::*;
#(
  parameter int NTGT  = 7,
  parameter int DEPTH = 32,
  parameter int LEN_W = 17,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_code,
  input  logic             cmd_dma,
  input  logic [7:0]       dest_id,
  input  logic [NTGT-1:0]  tgt_present,
  input  logic             fifo_wr,
  input  logic [7:0]       fifo_data,
  input  logic             dma_wr,
  input  logic [7:0]       dma_data,
  input  logic [LEN_W-1:0] exp_len,
  input  logic             tgt_done,
  input  logic             intr_rd,
  input  logic [AW-1:0]    cmd_raddr,
  output logic             cmd_issue,
  output logic [2:0]       cmd_tgt,
  output logic [2:0]       cmd_lun,
  output logic [CW-1:0]    cmd_len,
  output logic [7:0]       cmd_rdata,
  output logic             cmd_cancel,
  output logic [7:0]       stat_reg,
  output logic [7:0]       intr_reg,
  output logic [2:0]       seq_step,
  output logic             irq
);
  logic          ev_sel, ev_fail, ev_stop, ev_go, ev_event, buf_clr;
  logic          pend, active, id_off;
  logic          byte_wr;
  logic [7:0]    byte_in, buf_byte0;
  logic [CW-1:0] buf_cnt, rd_idx;
  logic [7:0]    stat_q, intr_q;
  logic [2:0]    seq_q;
  logic          irq_q;

  assign byte_wr  = fifo_wr || dma_wr;
  assign byte_in  = dma_wr ? dma_data : fifo_data;
  assign rd_idx   = CW'(cmd_raddr) + CW'(id_off);
  assign ev_event = ev_fail || ev_stop || cmd_issue;

  scsi_cmd_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(byte_wr), .wdata(byte_in), .clr(buf_clr),
    .rd_idx(rd_idx), .rdata(cmd_rdata), .byte0(buf_byte0), .cnt(buf_cnt)
  );

  scsi_sel_ctrl #(.NTGT(NTGT), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_dma(cmd_dma), .tgt_id(dest_id[2:0]),
    .tgt_present(tgt_present), .tgt_done(tgt_done), .buf_cnt(buf_cnt),
    .buf_byte0(buf_byte0), .ev_sel(ev_sel), .ev_fail(ev_fail), .ev_stop(ev_stop),
    .ev_go(ev_go), .buf_clr(buf_clr), .pend(pend), .active(active), .id_off(id_off),
    .cmd_issue(cmd_issue), .cmd_cancel(cmd_cancel), .cmd_tgt(cmd_tgt),
    .cmd_lun(cmd_lun), .cmd_len(cmd_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      intr_q <= '0;
      seq_q  <= '0;
      irq_q  <= 1'b0;
    end else if (ev_fail) begin
      stat_q <= ST_INT;
      intr_q <= IR_DISC;
      seq_q  <= SEQ_IDLE;
      irq_q  <= 1'b1;
    end else if (ev_stop) begin
      stat_q <= ST_INT | ST_TC | PH_CMD;
      intr_q <= IR_SVC_DONE;
      seq_q  <= SEQ_CMD;
      irq_q  <= 1'b1;
    end else if (cmd_issue) begin
      stat_q <= data_status(exp_len[LEN_W-1], exp_len == '0, stat_q);
      intr_q <= IR_SVC_DONE;
      seq_q  <= SEQ_CMD;
      irq_q  <= 1'b1;
    end else if (intr_rd) begin
      irq_q  <= 1'b0;
      stat_q <= stat_q & ~ST_INT;
    end
  end

  assign stat_reg = stat_q;
  assign intr_reg = intr_q;
  assign seq_step = seq_q;
  assign irq      = irq_q;
endmodule

// File: rtl/scsi_sel_seq_chk.sv
module scsi_sel_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rst,
  input logic       intr_rd,
  input logic       ev_sel,
  input logic       ev_fail,
  input logic       ev_stop,
  input logic       ev_go,
  input logic       ev_event,
  input logic       active,
  input logic       pend,
  input logic       cmd_issue,
  input logic       cmd_cancel,
  input logic [7:0] stat_reg,
  input logic [7:0] intr_reg,
  input logic [2:0] seq_step,
  input logic       irq
);
  p_fail_regs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> (stat_reg == 8'h80 && intr_reg == 8'h20 && seq_step == 3'd0 && irq && !cmd_issue));

  p_issue_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_go |=> cmd_issue);

  p_issue_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |=> !cmd_issue);

  p_data_regs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |=> (intr_reg == 8'h18 && seq_step == 3'd4 && irq));

  p_stop_regs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (stat_reg == 8'h92 && intr_reg == 8'h18 && seq_step == 3'd4 && irq && pend && !cmd_issue));

  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sel && active) |=> cmd_cancel);

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !intr_rd) |=> irq);

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_rd && !ev_event) |=> !irq);

  p_busrst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> !ev_sel);

  p_issue_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |-> !ev_sel);
endmodule

bind scsi_sel_seq scsi_sel_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .intr_rd(intr_rd), .ev_sel(ev_sel),
  .ev_fail(ev_fail), .ev_stop(ev_stop), .ev_go(ev_go), .ev_event(ev_event),
  .active(active), .pend(pend), .cmd_issue(cmd_issue), .cmd_cancel(cmd_cancel),
  .stat_reg(stat_reg), .intr_reg(intr_reg), .seq_step(seq_step), .irq(irq)
);

// File: tb/tb_scsi_sel_seq.sv
module tb_scsi_sel_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic bus_rst = 0, cmd_valid = 0, cmd_dma = 0, fifo_wr = 0, dma_wr = 0, tgt_done = 0, intr_rd = 0;
  logic [1:0] cmd_code = 0;
  logic [7:0] dest_id = 0, fifo_data = 0, dma_data = 0;
  logic [6:0] tgt_present = 0;
  logic signed [16:0] exp_len = 0;
  logic [4:0] cmd_raddr = 0;
  logic cmd_issue, cmd_cancel, irq;
  logic [2:0] cmd_tgt, cmd_lun, seq_step;
  logic [5:0] cmd_len;
  logic [7:0] cmd_rdata, stat_reg, intr_reg;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #10 clk = ~clk;

  scsi_sel_seq dut (.*);

  // Behavioural reference model
  int m_mem[32];
  int m_cnt, m_off, m_lun, m_tgt, m_len, m_stat, m_intr, m_seq;
  bit m_irq, m_issue, m_cancel, m_pend, m_active;
  bit prev_issue, selv, xfer, okt, evt, clear;
  int t;

  initial begin
    foreach (m_mem[i]) m_mem[i] = 0;
    {m_cnt, m_off, m_lun, m_tgt, m_len, m_stat, m_intr, m_seq} = '0;
    {m_irq, m_issue, m_cancel, m_pend, m_active} = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      {m_cnt, m_off, m_lun, m_tgt, m_len, m_stat, m_intr, m_seq} = '0;
      {m_irq, m_issue, m_cancel, m_pend, m_active} = '0;
    end else begin
      prev_issue = m_issue;
      selv = cmd_valid && (cmd_code == 1 || cmd_code == 2) && !bus_rst && !prev_issue;
      xfer = cmd_valid && cmd_code == 3 && m_pend && !prev_issue;
      t = int'(dest_id) % 8;
      okt = (t < 7) ? tgt_present[t] : 1'b0;
      m_cancel = selv && m_active;
      m_issue = 0;
      clear = 0;
      evt = prev_issue;
      if (selv) begin
        m_active = 0;
        m_pend = 0;
        evt = 1;
        if (!okt) begin
          m_stat = 'h80; m_intr = 'h20; m_seq = 0; m_irq = 1; clear = 1;
        end else begin
          m_off = (cmd_dma && m_cnt > 0) ? 1 : 0;
          m_lun = m_off ? (m_mem[0] % 8) : 0;
          m_tgt = t;
          if (cmd_code == 1) begin
            m_len = m_cnt - m_off; m_issue = 1; m_active = 1; clear = 1;
          end else begin
            m_stat = 'h92; m_intr = 'h18; m_seq = 4; m_irq = 1; m_pend = 1;
          end
        end
      end else if (xfer) begin
        m_len = m_cnt - m_off; m_issue = 1; m_active = 1; m_pend = 0; clear = 1;
      end else if (tgt_done) m_active = 0;
      if (prev_issue) begin
        if (exp_len > 0) m_stat = 'h91;
        else if (exp_len < 0) m_stat = 'h90;
        m_intr = 'h18; m_seq = 4; m_irq = 1;
      end
      if (intr_rd && !evt) begin
        m_irq = 0; m_stat = m_stat & 'h7f;
      end
      if (clear) m_cnt = 0;
      else if ((fifo_wr || dma_wr) && m_cnt < 32) begin
        m_mem[m_cnt] = dma_wr ? int'(dma_data) : int'(fifo_data);
        m_cnt++;
      end
    end
  end

  function automatic int model_rdata();
    int idx = int'(cmd_raddr) + m_off;
    return (idx < 32) ? m_mem[idx] : 0;
  endfunction

  // Compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    #2;
    if (!finished) begin
      checks++;
      if (stat_reg !== 8'(m_stat) || intr_reg !== 8'(m_intr) || seq_step !== 3'(m_seq) ||
          irq !== m_irq || cmd_issue !== m_issue || cmd_cancel !== m_cancel ||
          (m_issue && (cmd_tgt !== 3'(m_tgt) || cmd_lun !== 3'(m_lun) || cmd_len !== 6'(m_len) ||
                       cmd_rdata !== 8'(model_rdata())))) begin
        errors++;
        $display("FAIL %s model: act stat=%h intr=%h seq=%0d irq=%b iss=%b can=%b tgt=%0d lun=%0d len=%0d rd=%h exp stat=%h intr=%h seq=%0d irq=%b iss=%b can=%b tgt=%0d lun=%0d len=%0d rd=%h",
                 cur_req, stat_reg, intr_reg, seq_step, irq, cmd_issue, cmd_cancel, cmd_tgt, cmd_lun,
                 cmd_len, cmd_rdata, m_stat, m_intr, m_seq, m_irq, m_issue, m_cancel, m_tgt, m_lun,
                 m_len, model_rdata());
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input int code, input bit dma, input int id);
    cmd_valid = 1; cmd_code = 2'(code); cmd_dma = dma; dest_id = 8'(id);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wrb(input bit use_dma, input int d);
    if (use_dma) begin dma_wr = 1; dma_data = 8'(d); end
    else begin fifo_wr = 1; fifo_data = 8'(d); end
    @(negedge clk);
    dma_wr = 0; fifo_wr = 0;
  endtask

  task automatic pulse_rd();
    intr_rd = 1; @(negedge clk); intr_rd = 0;
  endtask

  task automatic pulse_done();
    tgt_done = 1; @(negedge clk); tgt_done = 0;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    cur_req = "R1";
    chk("R1 stat", stat_reg, 0); chk("R1 irq", irq, 0); chk("R1 issue", cmd_issue, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: absent and out-of-range targets
    cur_req = "R2";
    tgt_present = 7'b0000101;
    cmd(1, 0, 1);
    #3 chk("R2 stat", stat_reg, 'h80); chk("R2 intr", intr_reg, 'h20); chk("R2 irq", irq, 1);
    @(negedge clk);
    cur_req = "R9";
    pulse_rd();
    #3 chk("R9 irq cleared", irq, 0); chk("R9 stat bit7", stat_reg, 'h00);
    @(negedge clk);
    cur_req = "R2";
    tgt_present = 7'b1111111;
    cmd(2, 0, 7);
    #3 chk("R2 id7 intr", intr_reg, 'h20); chk("R2 id7 seq", seq_step, 0);
    @(negedge clk);
    pulse_rd();
    tgt_present = 7'b0000101;

    // R3/R4/R5: non-DMA select, positive length, upper ID bits set
    cur_req = "R3";
    exp_len = 8;
    wrb(0, 'h12); wrb(0, 'h34); wrb(0, 'h56);
    cmd(1, 0, 'hF2);
    #3 chk("R3 issue", cmd_issue, 1); chk("R3 tgt", cmd_tgt, 2); chk("R3 len", cmd_len, 3);
    chk("R4 lun zero identify", cmd_lun, 0);
    cmd_raddr = 1;
    #1 chk("R4 byte1", cmd_rdata, 'h34);
    @(negedge clk);
    cur_req = "R5";
    #3 chk("R5 stat data-in", stat_reg, 'h91); chk("R3 single pulse", cmd_issue, 0);
    chk("R5 seq", seq_step, 4);
    cmd_raddr = 0;
    @(negedge clk);
    pulse_rd();

    // R4/R8: DMA select with identify in buffer, negative length, old command active
    cur_req = "R8";
    exp_len = -4;
    wrb(1, 'hC5); wrb(1, 'hAA); wrb(1, 'hBB);
    cmd(1, 1, 0);
    #3 chk("R8 cancel", cmd_cancel, 1); chk("R4 dma lun", cmd_lun, 5); chk("R4 dma len", cmd_len, 2);
    #1 chk("R4 dma byte0", cmd_rdata, 'hAA);
    @(negedge clk);
    cur_req = "R5";
    #3 chk("R5 stat data-out", stat_reg, 'h90); chk("R8 cancel pulse", cmd_cancel, 0);
    @(negedge clk);
    pulse_rd();
    pulse_done();

    // R5 zero length leaves status; no cancel after done
    cur_req = "R5";
    exp_len = 0;
    wrb(0, 'h01);
    cmd(1, 0, 2);
    #3 chk("R8 no cancel after done", cmd_cancel, 0);
    @(negedge clk);
    #3 chk("R5 zero stat kept", stat_reg, 'h10); chk("R5 zero intr", intr_reg, 'h18); chk("R5 irq", irq, 1);
    @(negedge clk);
    pulse_rd();
    pulse_done();

    // R6/R7: select-and-stop, appended bytes, transfer
    cur_req = "R6";
    wrb(0, 'hA1);
    cmd(2, 0, 0);
    #3 chk("R6 stat", stat_reg, 'h92); chk("R6 seq", seq_step, 4); chk("R6 no issue", cmd_issue, 0);
    @(negedge clk);
    cur_req = "R7";
    wrb(0, 'hA2); wrb(0, 'hA3);
    exp_len = 5;
    cmd(3, 0, 0);
    #3 chk("R7 issue", cmd_issue, 1); chk("R7 len", cmd_len, 3);
    cmd_raddr = 2;
    #1 chk("R7 appended byte", cmd_rdata, 'hA3);
    @(negedge clk);
    cmd_raddr = 0;
    #3 chk("R7 stat", stat_reg, 'h91);
    @(negedge clk);
    pulse_rd();
    cmd(3, 0, 0);
    #3 chk("R7 xfer without pending", cmd_issue, 0); chk("R7 irq quiet", irq, 0);
    @(negedge clk);
    pulse_done();

    // R10: bus reset blocks select
    cur_req = "R10";
    bus_rst = 1;
    cmd(1, 0, 1);
    #3 chk("R10 irq", irq, 0); chk("R10 intr kept", intr_reg, 'h18);
    @(negedge clk);
    bus_rst = 0;

    // R12: command during strobe cycle ignored
    cur_req = "R12";
    exp_len = 2;
    wrb(0, 'h77);
    cmd(1, 0, 0);
    cmd(1, 0, 1);
    #3 chk("R12 intr", intr_reg, 'h18); chk("R12 seq", seq_step, 4);
    @(negedge clk);
    pulse_done();

    // R9: overwrite while pending, then hold
    cur_req = "R9";
    cmd(1, 0, 1);
    cmd(2, 0, 0);
    #3 chk("R9 overwrite", intr_reg, 'h18);
    repeat (3) @(negedge clk);
    #3 chk("R9 hold", irq, 1);
    @(negedge clk);
    pulse_rd();

    // R11: overflow and write priority
    cur_req = "R11";
    cmd(1, 0, 1);
    for (int i = 0; i < 34; i++) wrb(0, i + 1);
    exp_len = 1;
    cmd(1, 0, 0);
    #3 chk("R11 len capped", cmd_len, 32);
    cmd_raddr = 31;
    #1 chk("R11 last byte", cmd_rdata, 32);
    @(negedge clk);
    cmd_raddr = 0;
    pulse_done();
    fifo_wr = 1; fifo_data = 'h11; dma_wr = 1; dma_data = 'h22;
    @(negedge clk);
    fifo_wr = 0; dma_wr = 0;
    cmd(1, 0, 0);
    #3 chk("R11 dma priority", cmd_rdata, 'h22); chk("R11 len one", cmd_len, 1);
    @(negedge clk);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule